// File: doc/BRIEF.md
# Sixteen-by-eight divider with wrap-around quotient

This unit divides a 16-bit dividend, formed from an upper byte Y and a lower byte A, by an 8-bit divisor X. It matches one processor's divide instruction bit for bit. That includes the operands whose true quotient does not fit in eight bits. Such operands are neither saturated nor trapped. The unit returns a specific wrapped quotient and remainder, derived from a second division by 256 − X.

A one-cycle start pulse captures Y, A and X. The divider then runs a shift-and-subtract loop, one quotient bit per clock. Exactly twelve cycles after start it presents the new A (quotient byte), the new Y (remainder byte) and four flags, together with a one-cycle done pulse. The results stay on the outputs until the next operation completes.

The overflow flag and the half flag do not come from the result. They compare the incoming operands. The negative and zero flags look only at the final quotient byte.

Top module: `yax_divider`

## Requirements
- R1: `flag_h` is 1 when Y[3:0] >= X[3:0] (unsigned), else 0.
- R2: `flag_v` is 1 when Y >= X (unsigned bytes), else 0.
- R3: When Y < 2·X, `quo_a` is floor({Y,A}/X) mod 256 and `rem_y` is {Y,A} mod X.
- R4: When Y >= 2·X, with R = {Y,A} − 512·X and D = 256 − X, `quo_a` is 255 − floor(R/D) and `rem_y` is X + (R mod D).
- R5: X = 0 follows the rule of R4 with D = 256, so `quo_a` = 255 − Y and `rem_y` = A. No separate divide-by-zero path exists.
- R6: `flag_n` equals bit 7 of the final `quo_a`, and `flag_z` is 1 exactly when the final `quo_a` is zero.
- R7: If `start` is sampled high on an idle unit at clock edge k, then `done` is high for exactly the one cycle that follows edge k+12, and results appear in that same cycle.
- R8: `quo_a`, `rem_y` and all four flags change only in a cycle where `done` is high. They hold their values otherwise.
- R9: A `start` sampled while an operation is in progress (edges k through k+12) is ignored. Input changes during that window do not affect the result.
- R10: After reset, every output is 0 and `done` stays low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the unit is idle |
| y_in | input | 8 | Dividend upper byte Y |
| a_in | input | 8 | Dividend lower byte A |
| x_in | input | 8 | Divisor X |
| quo_a | output | 8 | Resulting A (quotient byte) |
| rem_y | output | 8 | Resulting Y (remainder byte) |
| flag_n | output | 1 | Negative flag from quo_a |
| flag_z | output | 1 | Zero flag from quo_a |
| flag_v | output | 1 | Y >= X comparison flag |
| flag_h | output | 1 | Low-nibble comparison flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several internal faults show up at the ports at the first done pulse after the operand that exercises them:
- a wrong branch choice;
- a partial remainder that was not restored;
- a misaligned divisor shift.

Each of these corrupts `quo_a` or `rem_y`. A miscounted phase counter moves `done` by at least one cycle, so the result is caught twelve cycles after start. A stray output update is visible in the very next cycle as a change with `done` low. The reference model predicts every output on every clock, so none of these faults can stay hidden past the operation that reveals it.

// File: rtl/yax_divider.sv
module yax_divider #(
  parameter int LATENCY = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] y_in,
  input  logic [7:0] a_in,
  input  logic [7:0] x_in,
  output logic [7:0] quo_a,
  output logic [7:0] rem_y,
  output logic       flag_n,
  output logic       flag_z,
  output logic       flag_v,
  output logic       flag_h,
  output logic       done
);
  localparam int QBITS = 9;
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST = CW'(LATENCY);
  localparam logic [CW-1:0] LAST_STEP = CW'(QBITS);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          big;
  logic [7:0]    op_x, op_y;
  logic          v_hold, h_hold;
  logic [16:0]   part;
  logic [16:0]   dsr;
  logic [7:0]    q;

  wire [15:0] ya      = {y_in, a_in};
  wire        go_big  = {1'b0, y_in} >= {x_in, 1'b0};
  wire [8:0]  div9    = go_big ? (9'd256 - {1'b0, x_in}) : {1'b0, x_in};
  wire [16:0] dvd     = go_big ? ({1'b0, ya} - {x_in, 9'b0}) : {1'b0, ya};
  wire        fits    = part >= dsr;
  wire [7:0]  fin_a   = big ? ~q : q;
  wire [7:0]  fin_y   = big ? (op_x + part[7:0]) : part[7:0];
  wire        stepping = busy && cnt >= CW'(1) && cnt <= LAST_STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; big <= 1'b0;
      op_x <= '0; op_y <= '0; v_hold <= 1'b0; h_hold <= 1'b0;
      part <= '0; dsr <= '0; q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        cnt    <= CW'(1);
        big    <= go_big;
        op_x   <= x_in;
        op_y   <= y_in;
        v_hold <= y_in >= x_in;
        h_hold <= y_in[3:0] >= x_in[3:0];
        part   <= dvd;
        dsr    <= {div9, 8'b0};
        q      <= '0;
      end
    end else begin
      cnt <= cnt + CW'(1);
      if (cnt == LAST) busy <= 1'b0;
      if (stepping) begin
        if (fits) part <= part - dsr;
        q   <= {q[6:0], fits};
        dsr <= dsr >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_a <= '0; rem_y <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0; flag_h <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy && cnt == LAST) begin
        quo_a  <= fin_a;
        rem_y  <= fin_y;
        flag_n <= fin_a[7];
        flag_z <= fin_a == 8'd0;
        flag_v <= v_hold;
        flag_h <= h_hold;
        done   <= 1'b1;
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({quo_a, rem_y, flag_n, flag_z, flag_v, flag_h}));

  assert_small_rem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !big) |-> (rem_y < op_x));

  assert_wrap_rem_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && big) |-> (rem_y >= op_x));

  assert_v_compare_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_v == (op_y >= op_x)));

  assert_h_compare_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_h == (op_y[3:0] >= op_x[3:0])));

  assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_x == 8'd0) |-> (quo_a == ~op_y));
endmodule

// File: tb/yax_divider_tb.sv
`timescale 1ns/1ps
module yax_divider_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] y_in = '0, a_in = '0, x_in = '0;
  logic [7:0] quo_a, rem_y;
  logic flag_n, flag_z, flag_v, flag_h, done;

  always #2 clk = ~clk;

  yax_divider u_dut (.clk, .rst_n, .start, .y_in, .a_in, .x_in,
    .quo_a, .rem_y, .flag_n, .flag_z, .flag_v, .flag_h, .done);

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // behavioural model state
  bit m_busy = 0;
  int m_cnt = 0;
  int p_a, p_y, p_n, p_z, p_v, p_h;
  string p_tag;
  int e_a = 0, e_y = 0, e_n = 0, e_z = 0, e_v = 0, e_h = 0, e_done = 0;
  string e_tag = "R10";

  task automatic ref_calc(input int y, input int a, input int x);
    int ya, qq, r, d;
    ya = y * 256 + a;
    if (y < 2 * x) begin
      qq = ya / x; p_a = qq % 256; p_y = ya - qq * x; p_tag = "R3";
    end else begin
      r = ya - 512 * x; d = 256 - x;
      p_a = 255 - r / d; p_y = x + r % d;
      p_tag = (x == 0) ? "R5" : "R4";
    end
    p_n = (p_a >= 128); p_z = (p_a == 0);
    p_v = (y >= x); p_h = ((y % 16) >= (x % 16));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      e_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 12) begin
          e_a = p_a; e_y = p_y; e_n = p_n; e_z = p_z; e_v = p_v; e_h = p_h;
          e_tag = p_tag; e_done = 1; m_busy = 0;
        end
      end else if (start) begin
        ref_calc(y_in, a_in, x_in);
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 done", done, e_done);
      chk({e_tag, "/R8 quotient"}, quo_a, e_a);
      chk({e_tag, "/R8 remainder"}, rem_y, e_y);
      chk("R6 N", flag_n, e_n);
      chk("R6 Z", flag_z, e_z);
      chk("R2 V", flag_v, e_v);
      chk("R1 H", flag_h, e_h);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // R9: optional second start mid-operation with other operands
  task automatic run_op(input int y, input int a, input int x, input bit meddle);
    @(negedge clk);
    y_in = 8'(y); a_in = 8'(a); x_in = 8'(x); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    y_in = 8'($urandom); a_in = 8'($urandom); x_in = 8'($urandom);
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (meddle && (i == 3 || i == 10)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values, compared on each clock by the model
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_op(0, 0, 0, 0);      // R5
    run_op(5, 7, 0, 0);      // R5
    run_op(255, 255, 0, 1);  // R5, R9
    run_op(0, 0, 1, 0);      // R3 zero quotient
    run_op(1, 255, 1, 0);    // R3 quotient truncation
    run_op(2, 0, 1, 0);      // R4 boundary Y == 2X
    run_op(255, 255, 1, 1);  // R4
    run_op(255, 255, 255, 0);
    run_op(254, 255, 255, 0);
    run_op(100, 50, 50, 0);  // R4 boundary
    run_op(99, 200, 50, 0);  // R3 just below
    run_op(0, 200, 7, 0);
    run_op(15, 0, 15, 0);    // R1 equal nibbles
    run_op(16, 3, 15, 0);    // R1 nibble below
    run_op(127, 255, 128, 0);
    run_op(200, 0, 128, 1);
    for (int k = 0; k < 300; k++)
      run_op(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
             (k % 7 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 255)),
             (k % 5 == 0));
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule